// File: doc/BRIEF.md
# Buffered serial transmitter

This block is an asynchronous serial transmitter with a one-byte staging register in front of its shift register. Software hands it a byte through a one-cycle write strobe. If the shifter is idle, the byte moves on to the shifter at once. If a frame is still going out, the byte waits in the staging register, so software can queue the next byte while the current one is sent. A status output shows when the staging register is free for another write.

Each frame has a start bit, eight data bits sent least significant bit first, an optional ninth bit, and a stop bit. The ninth bit can carry a value that software supplies, or a parity bit that the block computes. When both are enabled, parity wins. Bit timing comes from an external one-cycle baud tick. Every bit occupies the line from one tick to the next. A sticky completion flag rises as the stop bit begins and stays set until software clears it with a strobe.

Top module: `sertx_top`

## Requirements
- R1: After reset, `tx_out` is 1, `hold_empty` is 1 and `tx_done` is 0.
- R2: A clock edge with `wr_stb` high stores `wr_data` in the staging register, and `hold_empty` reads 0 after that edge.
- R3: When the shifter is idle, a staged byte moves into the shifter on the next clock edge, and `hold_empty` returns to 1 after that edge.
- R4: A byte written while a frame is in progress stays staged, with `hold_empty` at 0, through the tick that starts the current stop bit. It moves into the shifter on the edge that follows. The current frame's bits are not altered.
- R5: After a load, the line stays high until the next `baud_tick`. On that tick it drives the start bit (0). Each later tick drives the next bit: data bits 0 to 7, then the ninth bit if one is enabled, then the stop bit (1). `tx_out` changes only on a tick edge, and it idles at 1.
- R6: With `xbit_en`=1 and `par_en`=0, the ninth bit equals `xbit_val`. With both at 0, the frame has no ninth bit, and the stop bit follows data bit 7 directly.
- R7: With `par_en`=1, the ninth bit is parity chosen by `par_sel`: 00 gives odd parity (data plus parity has an odd count of ones), 01 gives even parity, 10 gives constant 1 and 11 gives constant 0. This applies whatever `xbit_en` and `xbit_val` are.
- R8: `tx_done` is set on the tick edge that drives the stop bit. It stays 1 until a `done_clr` edge clears it. If a set and a clear fall on the same edge, the set wins.
- R9: The ninth-bit configuration (`xbit_en`, `xbit_val`, `par_en`, `par_sel`) is captured when the byte enters the shifter. Later changes do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_stb | input | 1 | Write strobe for the staging register |
| wr_data | input | 8 | Byte to transmit |
| xbit_en | input | 1 | Enable the ninth bit taken from `xbit_val` |
| xbit_val | input | 1 | Software ninth-bit value |
| par_en | input | 1 | Enable the parity ninth bit (overrides `xbit_en`) |
| par_sel | input | 2 | Parity kind: 00 odd, 01 even, 10 mark, 11 space |
| done_clr | input | 1 | Clear strobe for `tx_done` |
| hold_empty | output | 1 | Staging register is free |
| tx_done | output | 1 | Sticky frame-complete flag |
| tx_out | output | 1 | Serial line |

## Verification
`hold_empty` falls one edge after a write strobe. With an idle shifter it rises again one edge later. With a busy shifter it rises on the second edge after the stop-bit tick. Each line bit appears after the tick edge that drives it, and `tx_done` rises on the same edge as the stop bit. The bench drives all inputs on falling edges, pulses the tick for exactly one cycle, and samples every output on the next falling edge, which is the first point where the registered result is visible. A sweep sends every byte value in each of seven ninth-bit modes. After each load it scrambles the configuration, so that capture at load time is checked on every frame.

// File: rtl/sertx_pkg.sv
// Shared definitions for the buffered serial transmitter.
// Assumes: parity selection is a 2-bit code driven straight from configuration.
package sertx_pkg;
    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_MARK  = 2'b10,
        PAR_SPACE = 2'b11
    } par_kind_t;
endpackage

// File: rtl/sertx_hold.sv
// Single-entry staging register in front of the shifter.
// Assumes: a write while already full overwrites the staged byte; a write in the
// same cycle as a take leaves the register full with the new byte.
module sertx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full
);
    // Capture written bytes and drop the full state when the shifter takes one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else if (wr_stb) begin
            hold_data <= wr_data;
            hold_full <= 1'b1;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end
endmodule

// File: rtl/sertx_framer.sv
// Builds the line frame (start, data LSB first, optional ninth bit, stop) and
// its length from a byte and the ninth-bit configuration. Purely combinational.
// Assumes: parity overrides the software extra bit when both are enabled.
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 3,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  logic               xbit_en,
    input  logic               xbit_val,
    input  logic               par_en,
    input  logic [1:0]         par_sel,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   nbits
);
    logic ninth_on;
    logic ninth_val;
    logic par_bit;

    // Choose the parity bit from the selected kind.
    always_comb begin
        unique case (par_kind_t'(par_sel))
            PAR_ODD:   par_bit = ~(^data);
            PAR_EVEN:  par_bit = ^data;
            PAR_MARK:  par_bit = 1'b1;
            default:   par_bit = 1'b0;
        endcase
    end

    // Resolve presence and value of the ninth bit, parity first.
    always_comb begin
        ninth_on  = par_en | xbit_en;
        ninth_val = par_en ? par_bit : xbit_val;
    end

    // Assemble the frame with the start bit at index 0; unused tail bits are stop level.
    always_comb begin
        frame              = '1;
        frame[0]           = 1'b0;
        frame[DATA_W:1]    = data;
        if (ninth_on) begin
            frame[DATA_W+1] = ninth_val;
        end
        nbits = ninth_on ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
    end
endmodule

// File: rtl/sertx_shifter.sv
// Frame shifter: drives one frame bit per baud tick and frees itself on the tick
// that starts the stop bit, so the next frame's start bit follows one full stop period.
// Assumes: load is only asserted while busy is low.
module sertx_shifter #(
    parameter int FRAME_W = 11,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [CNT_W-1:0]   nbits_in,
    input  logic               baud_tick,
    output logic               busy,
    output logic               tx_out,
    output logic               stop_start
);
    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   left;

    // Flags the tick that puts the stop bit on the line.
    assign stop_start = busy && baud_tick && (left == CNT_W'(1));

    // Load a frame, then shift one bit to the line on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '1;
            left   <= '0;
            busy   <= 1'b0;
            tx_out <= 1'b1;
        end else if (load) begin
            sh   <= frame_in;
            left <= nbits_in;
            busy <= 1'b1;
        end else if (busy && baud_tick) begin
            tx_out <= sh[0];
            sh     <= {1'b1, sh[FRAME_W-1:1]};
            left   <= left - CNT_W'(1);
            if (left == CNT_W'(1)) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sertx_top.sv
// Buffered serial transmitter: staging register, framer, shifter and sticky
// completion flag. Assumes an external one-cycle baud tick and synchronous active-low reset.
module sertx_top #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              xbit_en,
    input  logic              xbit_val,
    input  logic              par_en,
    input  logic [1:0]        par_sel,
    input  logic              done_clr,
    output logic              hold_empty,
    output logic              tx_done,
    output logic              tx_out
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [DATA_W-1:0]  hold_data;
    logic               hold_full;
    logic               sh_busy;
    logic               take;
    logic               stop_start;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits;

    assign take       = hold_full & ~sh_busy;
    assign hold_empty = ~hold_full;

    sertx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .take      (take),
        .hold_data (hold_data),
        .hold_full (hold_full)
    );

    sertx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
        .data     (hold_data),
        .xbit_en  (xbit_en),
        .xbit_val (xbit_val),
        .par_en   (par_en),
        .par_sel  (par_sel),
        .frame    (frame),
        .nbits    (nbits)
    );

    sertx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (take),
        .frame_in   (frame),
        .nbits_in   (nbits),
        .baud_tick  (baud_tick),
        .busy       (sh_busy),
        .tx_out     (tx_out),
        .stop_start (stop_start)
    );

    // Sticky completion flag; a set on the stop tick beats a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done <= 1'b0;
        end else if (stop_start) begin
            tx_done <= 1'b1;
        end else if (done_clr) begin
            tx_done <= 1'b0;
        end
    end
endmodule

// File: rtl/sertx_chk.sv
// Temporal checks on the buffered serial transmitter, attached by bind.
// Assumes: busy is the shifter's internal frame-in-progress state.
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_stb,
    input logic done_clr,
    input logic baud_tick,
    input logic hold_empty,
    input logic tx_done,
    input logic tx_out,
    input logic busy
);
    p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !hold_empty);

    p_idle_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !hold_empty && !wr_stb) |=> (hold_empty && busy));

    p_busy_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !hold_empty && !baud_tick) |=> !hold_empty);

    p_line_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(tx_out));

    p_stop_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> tx_out);

    p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !done_clr) |=> tx_done);

    p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> ($past(baud_tick) && !busy));
endmodule

bind sertx_top sertx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .done_clr   (done_clr),
    .baud_tick  (baud_tick),
    .hold_empty (hold_empty),
    .tx_done    (tx_done),
    .tx_out     (tx_out),
    .busy       (sh_busy)
);

// File: tb/tb_sertx_top.sv
// Self-checking bench: sweeps every byte through seven ninth-bit modes, then
// checks queuing behind a busy shifter and the set-beats-clear rule.
module tb_sertx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       xbit_en = 1'b0;
    logic       xbit_val = 1'b0;
    logic       par_en = 1'b0;
    logic [1:0] par_sel = 2'b00;
    logic       done_clr = 1'b0;
    logic       hold_empty;
    logic       tx_done;
    logic       tx_out;

    int nchecks = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    sertx_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .xbit_en    (xbit_en),
        .xbit_val   (xbit_val),
        .par_en     (par_en),
        .par_sel    (par_sel),
        .done_clr   (done_clr),
        .hold_empty (hold_empty),
        .tx_done    (tx_done),
        .tx_out     (tx_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Modes: 0 none, 1 extra=0, 2 extra=1, 3 odd, 4 even, 5 mark, 6 space.
    function automatic logic ninth_of(input logic [7:0] d, input int mode);
        int ones = $countones(d);
        case (mode)
            1: return 1'b0;
            2: return 1'b1;
            3: return (ones % 2 == 0) ? 1'b1 : 1'b0;
            4: return (ones % 2 == 1) ? 1'b1 : 1'b0;
            5: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int len_of(input int mode);
        return (mode == 0) ? 10 : 11;
    endfunction

    function automatic logic exp_bit(input logic [7:0] d, input int mode, input int i);
        if (i == 0) return 1'b0;
        if (i <= 8) return d[i-1];
        if (i == 9 && mode != 0) return ninth_of(d, mode);
        return 1'b1;
    endfunction

    task automatic set_cfg(input logic [7:0] d, input int mode);
        xbit_en  = (mode != 0);
        par_en   = (mode >= 3);
        par_sel  = (mode >= 3) ? 2'(mode - 3) : 2'b00;
        xbit_val = (mode >= 3) ? ~ninth_of(d, mode) : (mode == 2);
    endtask

    task automatic scramble_cfg();
        xbit_en  = ~xbit_en;
        par_en   = ~par_en;
        par_sel  = ~par_sel;
        xbit_val = ~xbit_val;
    endtask

    // One-cycle tick; returns at the falling edge after the tick edge.
    task automatic tick();
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input int mode);
        int n = len_of(mode);
        @(negedge clk);
        set_cfg(d, mode);
        wr_data = d;
        wr_stb  = 1'b1;
        @(negedge clk) wr_stb = 1'b0;
        chk("R2 hold_empty after write", 32'(hold_empty), 32'd0);
        @(negedge clk);
        chk("R3 hold_empty after move", 32'(hold_empty), 32'd1);
        scramble_cfg();   // R9: later config must not matter
        chk("R5 line high before start", 32'(tx_out), 32'd1);
        for (int i = 0; i < n; i++) begin
            tick();
            chk((mode == 0) ? "R5 frame bit" : (mode < 3 ? "R6 frame bit" : "R7 frame bit"),
                {d, 8'(mode), 8'(i), 7'd0, tx_out}, {d, 8'(mode), 8'(i), 7'd0, exp_bit(d, mode, i)});
            if (i == n - 2) chk("R8 done low before stop", 32'(tx_done), 32'd0);
            if (i == n - 1) chk("R8 done at stop", 32'(tx_done), 32'd1);
        end
        @(negedge clk);
        chk("R8 done sticky", 32'(tx_done), 32'd1);
        done_clr = 1'b1;
        @(negedge clk) done_clr = 1'b0;
        chk("R8 done cleared", 32'(tx_done), 32'd0);
    endtask

    task automatic queued_test();
        logic [7:0] a = 8'hA5;
        logic [7:0] b = 8'h3C;
        @(negedge clk);
        set_cfg(a, 0);
        wr_data = a;
        wr_stb  = 1'b1;
        @(negedge clk) wr_stb = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            tick();
            chk("R4 first frame bit", {8'(i), 23'd0, tx_out}, {8'(i), 23'd0, exp_bit(a, 0, i)});
            if (i == 2) begin
                set_cfg(b, 0);
                wr_data = b;
                wr_stb  = 1'b1;
                @(negedge clk) wr_stb = 1'b0;
                chk("R4 staged while busy", 32'(hold_empty), 32'd0);
            end
            if (i >= 3) chk("R4 still staged", 32'(hold_empty), 32'd0);
        end
        @(negedge clk);
        chk("R4 moved after stop tick", 32'(hold_empty), 32'd1);
        chk("R5 stop holds line", 32'(tx_out), 32'd1);
        for (int i = 0; i < 10; i++) begin
            if (i == 9) begin
                @(negedge clk);
                baud_tick = 1'b1;
                done_clr  = 1'b1;
                @(negedge clk);
                baud_tick = 1'b0;
                done_clr  = 1'b0;
                chk("R8 set beats clear", 32'(tx_done), 32'd1);
            end else begin
                tick();
                if (i == 0) begin
                    done_clr = 1'b1;
                    @(negedge clk) done_clr = 1'b0;
                    chk("R8 cleared mid frame", 32'(tx_done), 32'd0);
                end
            end
            chk("R4 second frame bit", {8'(i), 23'd0, tx_out}, {8'(i), 23'd0, exp_bit(b, 0, i)});
        end
        done_clr = 1'b1;
        @(negedge clk) done_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset tx_out", 32'(tx_out), 32'd1);
        chk("R1 reset hold_empty", 32'(hold_empty), 32'd1);
        chk("R1 reset tx_done", 32'(tx_done), 32'd0);
        for (int m = 0; m < 7; m++) begin
            for (int d = 0; d < 256; d++) begin
                send_frame(8'(d), m);
            end
        end
        queued_test();
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nchecks++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end
endmodule